// File: doc/BRIEF.md
# Byte-Stream Command Dispatcher

This block sits between a host-side receive FIFO and a host-side transmit FIFO. It reads a stream of bytes. Each command is an opcode followed by zero, one or two argument bytes. The block collects the arguments and then carries out the command. It handles several commands itself: it programs the value and direction of a low bank of general-purpose lines and a high bank, reads either bank back, switches an internal serial loopback, stalls on the level of one high-bank line, requests a flush of buffered results, and reports opcodes it does not know. Two kinds of command go to neighbouring blocks. Serial shift commands go to a shift engine, which takes over the receive stream for any payload. The divisor command loads a clock generator.

The control is a single state machine with seven states. S_IDLE takes an opcode. S_ARG1 and S_ARG2 take the argument bytes. S_EXEC carries out the command for one cycle. S_ERR2 sends the second byte of an error report. S_WAIT stalls on the watched line. S_SHIFT waits for the shift engine to finish. The transitions are as follows. S_IDLE moves to S_EXEC when the opcode has no arguments, and to S_ARG1 otherwise. S_ARG1 moves to S_ARG2 when a second argument is due, and to S_EXEC otherwise. S_ARG2 moves to S_EXEC. From S_EXEC the machine goes to S_ERR2 for an unknown opcode, to S_WAIT for a wait command, to S_SHIFT for a shift command, and back to S_IDLE for all others. S_ERR2 returns to S_IDLE. S_WAIT returns to S_IDLE when the line reaches the requested level. S_SHIFT returns to S_IDLE on the engine's done pulse. When the enable input is low, the whole block is held in its reset state.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, and on the clock edge after `enable` is sampled low, `lo_oe`, `hi_oe` and `loop_en` are all zero and the machine is in S_IDLE. While `enable` is low, `rx_ready` is 0.
- R2: Opcode 0x80 followed by bytes V and D sets `lo_out` to V and `lo_oe` to D. A 1 in D means that line is driven with the matching bit of V. Both outputs change on the clock edge that ends S_EXEC.
- R3: Opcode 0x82 followed by V and D sets `hi_out` to V[3:0] and `hi_oe` to D[3:0].
- R4: Opcode 0x81 sends one byte equal to `lo_in`. While loopback is on, bit 2 of that byte is replaced by `lo_out` bit 1.
- R5: Opcode 0x83 sends one byte with `hi_in` in bits 3:0 and zeros in bits 7:4.
- R6: Opcode 0x84 sets `loop_en` to 1 and opcode 0x85 clears it.
- R7: Opcode 0x88 stalls the stream until `hi_in` bit 1 is 1. Opcode 0x89 stalls until that bit is 0. During the stall `rx_ready` stays 0.
- R8: Opcode 0x87 raises `tx_flush` for exactly one cycle.
- R9: Opcode 0x86 followed by bytes L and H raises `div_load` for one cycle, with `div_value` = {H,L} during that cycle.
- R10: An opcode with bit 7 set that is not one of 0x80 to 0x89 causes two bytes to be sent in consecutive cycles: 0xFA, then the opcode.
- R11: An opcode with bit 7 clear is a shift command. It takes one length byte when opcode bit 1 is 1 and two length bytes (low byte first) when bit 1 is 0. `sh_start` pulses for one cycle with `sh_op` set to the opcode and `sh_len` set to the length, zero-extended when it is a single byte. No byte is taken from the stream until `sh_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable; while low the block is held in reset |
| rx_valid | input | 1 | Receive FIFO has a byte |
| rx_data | input | 8 | Receive FIFO byte |
| rx_ready | output | 1 | Byte is taken on this clock edge when rx_valid is also high |
| tx_valid | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed to the transmit FIFO |
| tx_flush | output | 1 | One-cycle request to flush the transmit FIFO to the host |
| lo_in | input | 8 | Low bank pin levels |
| lo_out | output | 8 | Low bank output values |
| lo_oe | output | 8 | Low bank output enables |
| hi_in | input | 4 | High bank pin levels |
| hi_out | output | 4 | High bank output values |
| hi_oe | output | 4 | High bank output enables |
| loop_en | output | 1 | Serial loopback switch |
| div_load | output | 1 | Load strobe to the clock generator |
| div_value | output | 16 | Divisor value, valid while div_load is high |
| sh_start | output | 1 | Start strobe to the shift engine |
| sh_op | output | 8 | Shift opcode |
| sh_len | output | 16 | Shift length field |
| sh_done | input | 1 | Shift engine completion pulse |

## Verification
The command stream is tested with each argument count: zero-argument reads and toggles, one-byte bit-mode shifts, and two-byte settings, divisors and byte-mode shifts. This separates errors in collecting arguments from errors in carrying out a command. Readbacks are repeated with loopback on and off, using line values chosen so that only the loopback substitution can set bit 2. Unknown opcodes are placed between good commands to confirm that the two-byte report keeps its order and that the stream recovers afterwards. Both wait polarities are held for several cycles and then released, and a disable in the middle of the stream checks that every output enable and the loopback clear.

// File: rtl/dsp_cmd_pkg.sv
package dsp_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_ARG1, S_ARG2, S_EXEC, S_ERR2, S_WAIT, S_SHIFT
    } state_t;

    typedef enum logic [3:0] {
        C_SETLO, C_SETHI, C_RDLO, C_RDHI, C_LOOPON, C_LOOPOFF,
        C_DIV, C_FLUSH, C_WAITHI, C_WAITLO, C_SHIFT, C_BAD
    } cls_t;

    localparam logic [7:0] OP_SETLO   = 8'h80;
    localparam logic [7:0] OP_RDLO    = 8'h81;
    localparam logic [7:0] OP_SETHI   = 8'h82;
    localparam logic [7:0] OP_RDHI    = 8'h83;
    localparam logic [7:0] OP_LOOPON  = 8'h84;
    localparam logic [7:0] OP_LOOPOFF = 8'h85;
    localparam logic [7:0] OP_DIV     = 8'h86;
    localparam logic [7:0] OP_FLUSH   = 8'h87;
    localparam logic [7:0] OP_WAITHI  = 8'h88;
    localparam logic [7:0] OP_WAITLO  = 8'h89;
    localparam logic [7:0] ERR_MARK   = 8'hFA;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import dsp_cmd_pkg::*;
(
    input  logic [7:0] op,
    output cls_t       cls,
    output logic [1:0] nargs
);
    always_comb begin
        cls   = C_BAD;
        nargs = 2'd0;
        if (!op[7]) begin
            cls   = C_SHIFT;
            nargs = op[1] ? 2'd1 : 2'd2;
        end else begin
            unique case (op)
                OP_SETLO:   begin cls = C_SETLO; nargs = 2'd2; end
                OP_SETHI:   begin cls = C_SETHI; nargs = 2'd2; end
                OP_DIV:     begin cls = C_DIV;   nargs = 2'd2; end
                OP_RDLO:    cls = C_RDLO;
                OP_RDHI:    cls = C_RDHI;
                OP_LOOPON:  cls = C_LOOPON;
                OP_LOOPOFF: cls = C_LOOPOFF;
                OP_FLUSH:   cls = C_FLUSH;
                OP_WAITHI:  cls = C_WAITHI;
                OP_WAITLO:  cls = C_WAITLO;
                default:    cls = C_BAD;
            endcase
        end
    end
endmodule

// File: rtl/line_bank.sv
module line_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] val_in,
    input  logic [W-1:0] dir_in,
    output logic [W-1:0] val_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            dir_q <= '0;
        end else if (clr) begin
            val_q <= '0;
            dir_q <= '0;
        end else if (load) begin
            val_q <= val_in;
            dir_q <= dir_in;
        end
    end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
    import dsp_cmd_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int HI_W     = 4,
    parameter int WAIT_BIT = 1,
    parameter int LB_OUT   = 1,
    parameter int LB_IN    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    output logic            rx_ready,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    output logic            tx_flush,
    input  logic [LO_W-1:0] lo_in,
    output logic [LO_W-1:0] lo_out,
    output logic [LO_W-1:0] lo_oe,
    input  logic [HI_W-1:0] hi_in,
    output logic [HI_W-1:0] hi_out,
    output logic [HI_W-1:0] hi_oe,
    output logic            loop_en,
    output logic            div_load,
    output logic [15:0]     div_value,
    output logic            sh_start,
    output logic [7:0]      sh_op,
    output logic [15:0]     sh_len,
    input  logic            sh_done
);
    state_t     st, st_nx;
    cls_t       cls;
    logic [1:0] nargs;
    logic [7:0] op_q, a1_q, a2_q, cls_in;
    logic [7:0] lo_rd, hi_rd;
    logic       take, wait_lvl, in_exec;

    assign cls_in  = (st == S_IDLE) ? rx_data : op_q;
    assign take    = rx_valid && rx_ready;
    assign in_exec = (st == S_EXEC);
    assign wait_lvl = (cls == C_WAITHI);

    cmd_classify u_cls (.op(cls_in), .cls(cls), .nargs(nargs));

    line_bank #(.W(LO_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .clr(!enable),
        .load(in_exec && cls == C_SETLO),
        .val_in(a1_q[LO_W-1:0]), .dir_in(a2_q[LO_W-1:0]),
        .val_q(lo_out), .dir_q(lo_oe));

    line_bank #(.W(HI_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(!enable),
        .load(in_exec && cls == C_SETHI),
        .val_in(a1_q[HI_W-1:0]), .dir_in(a2_q[HI_W-1:0]),
        .val_q(hi_out), .dir_q(hi_oe));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= S_IDLE;
        else if (!enable) st <= S_IDLE;
        else              st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0; a1_q <= '0; a2_q <= '0; loop_en <= 1'b0;
        end else if (!enable) begin
            op_q <= '0; a1_q <= '0; a2_q <= '0; loop_en <= 1'b0;
        end else begin
            if (take && st == S_IDLE) begin
                op_q <= rx_data;
                a1_q <= '0;
                a2_q <= '0;
            end
            if (take && st == S_ARG1) a1_q <= rx_data;
            if (take && st == S_ARG2) a2_q <= rx_data;
            if (in_exec && cls == C_LOOPON)  loop_en <= 1'b1;
            if (in_exec && cls == C_LOOPOFF) loop_en <= 1'b0;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (rx_valid) st_nx = (nargs == 2'd0) ? S_EXEC : S_ARG1;
            S_ARG1:  if (rx_valid) st_nx = (nargs == 2'd2) ? S_ARG2 : S_EXEC;
            S_ARG2:  if (rx_valid) st_nx = S_EXEC;
            S_EXEC: begin
                case (cls)
                    C_BAD:              st_nx = S_ERR2;
                    C_WAITHI, C_WAITLO: st_nx = S_WAIT;
                    C_SHIFT:            st_nx = S_SHIFT;
                    default:            st_nx = S_IDLE;
                endcase
            end
            S_ERR2:  st_nx = S_IDLE;
            S_WAIT:  if (hi_in[WAIT_BIT] == wait_lvl) st_nx = S_IDLE;
            S_SHIFT: if (sh_done) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // readback bytes
    always_comb begin
        lo_rd = '0;
        lo_rd[LO_W-1:0] = lo_in;
        if (loop_en) lo_rd[LB_IN] = lo_out[LB_OUT];
        hi_rd = '0;
        hi_rd[HI_W-1:0] = hi_in;
    end

    // outputs
    always_comb begin
        rx_ready  = enable && (st == S_IDLE || st == S_ARG1 || st == S_ARG2);
        tx_valid  = 1'b0;
        tx_data   = '0;
        if (in_exec && cls == C_RDLO) begin tx_valid = 1'b1; tx_data = lo_rd;    end
        if (in_exec && cls == C_RDHI) begin tx_valid = 1'b1; tx_data = hi_rd;    end
        if (in_exec && cls == C_BAD)  begin tx_valid = 1'b1; tx_data = ERR_MARK; end
        if (st == S_ERR2)             begin tx_valid = 1'b1; tx_data = op_q;     end
        tx_flush  = in_exec && cls == C_FLUSH;
        div_load  = in_exec && cls == C_DIV;
        div_value = {a2_q, a1_q};
        sh_start  = in_exec && cls == C_SHIFT;
        sh_op     = op_q;
        sh_len    = op_q[1] ? {8'h00, a1_q} : {a2_q, a1_q};
    end

    // R10: second report byte follows the marker
    p_bad_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && cls == C_BAD && enable) |=> (tx_valid && tx_data == op_q));
    // R11: nothing consumed right after a shift is launched
    p_shift_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !rx_ready);
    // R7: unmet wait keeps the stream closed
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && hi_in[WAIT_BIT] != wait_lvl) |=> !rx_ready);
    // R1: disable clears all drivers and loopback
    p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (lo_oe == '0 && hi_oe == '0 && !loop_en));
    // R8: flush is a single-cycle pulse
    p_flush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> !tx_flush);
    // R9: strobes to neighbours never coincide
    p_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, tx_flush, div_load, sh_start}));
endmodule

// File: tb/sim_cmd_dispatch.sv
`timescale 1ns/1ps
module sim_cmd_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, enable = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_flush, loop_en, div_load, sh_start;
    logic [7:0]  tx_data, lo_out, lo_oe, sh_op;
    logic [7:0]  lo_in = '0;
    logic [3:0]  hi_in = '0;
    logic [3:0]  hi_out, hi_oe;
    logic [15:0] div_value, sh_len;
    logic        sh_done = 1'b0;

    int vec = 0, fails = 0;
    int flush_cnt = 0, div_cnt = 0, sh_cnt = 0, sh_timer = 0;
    bit sh_busy = 0;
    logic [15:0] last_div, last_len;
    logic [7:0]  last_op;
    logic [7:0]  exp_q[$];

    always #2 clk = ~clk;

    cmd_dispatch u0 (.*);

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // reference monitor, every clock
    always @(negedge clk) begin
        if (sh_done) sh_busy = 0;
        if (sh_busy && rx_ready) begin
            fails++; vec++;
            $display("FAIL R11: actual rx_ready 1 expected 0 during shift");
        end
        if (tx_valid) begin
            if (exp_q.size() == 0) chk("R10/R4/R5 unexpected tx", {8'h0, tx_data}, 16'hFFFF);
            else chk("R4/R5/R10 tx byte", {8'h0, tx_data}, {8'h0, exp_q.pop_front()});
        end
        if (tx_flush) flush_cnt++;
        if (div_load) begin div_cnt++; last_div = div_value; end
        sh_done = 1'b0;
        if (sh_timer > 0) begin
            sh_timer--;
            if (sh_timer == 0) sh_done = 1'b1;
        end
        if (sh_start) begin
            sh_cnt++; last_op = sh_op; last_len = sh_len; sh_timer = 4; sh_busy = 1;
        end
    end

    task automatic send(input logic [7:0] b);
        bit ok;
        rx_valid = 1'b1; rx_data = b;
        forever begin
            ok = rx_ready;
            @(negedge clk);
            if (ok) break;
        end
        rx_valid = 1'b0;
    endtask

    task automatic idle_wait();
        do @(negedge clk); while (!rx_ready);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lo_oe", {8'h0, lo_oe}, 16'h0);
        chk("R1 hi_oe", {12'h0, hi_oe}, 16'h0);
        chk("R1 loop_en", {15'h0, loop_en}, 16'h0);
        chk("R1 rx_ready", {15'h0, rx_ready}, 16'h1);

        // R2 low bank
        send(8'h80); send(8'hA5); send(8'h3C); idle_wait();
        chk("R2 lo_out", {8'h0, lo_out}, 16'h00A5);
        chk("R2 lo_oe", {8'h0, lo_oe}, 16'h003C);
        // R3 high bank
        send(8'h82); send(8'hF6); send(8'hF3); idle_wait();
        chk("R3 hi_out", {12'h0, hi_out}, 16'h6);
        chk("R3 hi_oe", {12'h0, hi_oe}, 16'h3);

        // R4 / R5 reads
        lo_in = 8'h5A; exp_q.push_back(8'h5A); send(8'h81); idle_wait();
        hi_in = 4'b1001; exp_q.push_back(8'h09); send(8'h83); idle_wait();

        // R6 loopback with R4 substitution
        send(8'h80); send(8'h06); send(8'hFF); idle_wait();
        send(8'h84); idle_wait();
        chk("R6 loop on", {15'h0, loop_en}, 16'h1);
        lo_in = 8'h00; exp_q.push_back(8'h04); send(8'h81); idle_wait();
        send(8'h85); idle_wait();
        chk("R6 loop off", {15'h0, loop_en}, 16'h0);
        exp_q.push_back(8'h00); send(8'h81); idle_wait();

        // R8 flush
        send(8'h87); idle_wait();
        chk("R8 flush count", flush_cnt[15:0], 16'd1);
        // R9 divisor
        send(8'h86); send(8'h34); send(8'h12); idle_wait();
        chk("R9 div count", div_cnt[15:0], 16'd1);
        chk("R9 div value", last_div, 16'h1234);

        // R10 unknown opcodes between good commands
        exp_q.push_back(8'hFA); exp_q.push_back(8'h91); send(8'h91);
        exp_q.push_back(8'hFA); exp_q.push_back(8'h8A); send(8'h8A);
        hi_in = 4'b0110; exp_q.push_back(8'h06); send(8'h83); idle_wait();
        chk("R10 queue drained", exp_q.size(), 16'd0);

        // R11 shifts, byte then bit mode
        send(8'h19); send(8'h03); send(8'h01); idle_wait();
        chk("R11 op", {8'h0, last_op}, 16'h0019);
        chk("R11 len2", last_len, 16'h0103);
        send(8'h1B); send(8'h05); idle_wait();
        chk("R11 op bit", {8'h0, last_op}, 16'h001B);
        chk("R11 len1", last_len, 16'h0005);
        chk("R11 count", sh_cnt[15:0], 16'd2);

        // R7 waits
        hi_in = 4'b0000; send(8'h88);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R7 stall hi", {15'h0, rx_ready}, 16'h0);
        end
        hi_in = 4'b0010; idle_wait();
        chk("R7 released hi", {15'h0, rx_ready}, 16'h1);
        send(8'h89);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7 stall lo", {15'h0, rx_ready}, 16'h0);
        end
        hi_in = 4'b0000; idle_wait();
        chk("R7 released lo", {15'h0, rx_ready}, 16'h1);

        // R1 disable mid-stream
        send(8'h84); idle_wait();
        enable = 1'b0;
        @(negedge clk);
        chk("R1 dis lo_oe", {8'h0, lo_oe}, 16'h0);
        chk("R1 dis hi_oe", {12'h0, hi_oe}, 16'h0);
        chk("R1 dis loop", {15'h0, loop_en}, 16'h0);
        chk("R1 dis ready", {15'h0, rx_ready}, 16'h0);
        enable = 1'b1;
        @(negedge clk);
        chk("R1 re-enable lo_out", {8'h0, lo_out}, 16'h0);
        repeat (4) @(negedge clk);
        chk("R10 final queue", exp_q.size(), 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end
endmodule